// File: doc/BRIEF.md
# UART Receiver with Moderated Interrupt

This block receives asynchronous serial bytes (one start bit, eight data bits, one stop bit), stores them in a receive FIFO, and raises a single interrupt line to the processor. To reduce interrupt load under heavy traffic, the receive interrupt does not fire on every character. It fires when the FIFO reaches a fill threshold, which defaults to half its depth. It also fires when data has been waiting longer than a timeout window, so that a short trailing burst is still reported. Error conditions (overrun, bad stop bit, line break) are kept as sticky status bits. Each status bit can be routed to the interrupt through its own enable bit.

Software reaches the block through four word registers. Address 0 pops the FIFO. Address 1 gives status, and a write to it clears sticky bits. Address 2 holds the interrupt enables. Address 3 holds the oversample divisor, which sets the bit rate as clock frequency divided by (16 × divisor). The timeout counter runs on the oversample tick, so the window scales with the bit rate. With the default parameters at a 125 MHz clock and 115200 baud, the window is several milliseconds.

Top module: `uart_rx_irqmod`

## Requirements
- R1: Frames are a low start bit, eight data bits least significant first, and a high stop bit, sampled with 16 oversample ticks per bit. The start bit is confirmed half a bit after the falling edge, so a low pulse shorter than that stores no byte and sets no flag.
- R2: The oversample tick period in clock cycles equals the divisor register at address 3, with 0 treated as 1. The register resets to DIV_RST and reads back what was written.
- R3: Address 0 returns bytes in arrival order. Bits 7:0 hold the oldest byte and bit 8 is 1 when a byte was present. A read with bit 8 set removes that byte.
- R4: Status bit 7 (threshold) is 1 exactly while the FIFO holds at least THRESH bytes (default DEPTH/2).
- R5: A timeout counter advances on each oversample tick while its top bit is clear. A tick that finds the top bit set and the FIFO holding data holds the counter and sets status bit 6. Bit 6 is 0 after any tick where the top bit was clear.
- R6: Once set, status bit 6 stays set until a tick finds the FIFO empty. That tick clears the bit and the counter together.
- R7: A byte that completes while the FIFO is full is dropped and sets the sticky overrun bit, status bit 1.
- R8: A stop bit sampled low sets the sticky framing bit, status bit 2, and the byte is not stored. The receiver waits for a high line before it looks for a new start bit.
- R9: A frame whose start, data and stop samples are all low also sets the sticky break bit, status bit 4.
- R10: Status bit 5 is the OR of the overrun, framing, parity and break bits. The parity bit, status bit 3, always reads 0 with this framing. A write to address 1 clears each sticky bit whose write-data bit is 1.
- R11: Status bit 0 (receive ready) is the OR of threshold and timeout. irq is registered: it is 1 one cycle after any status bit in 5:0 is 1 together with the matching enable bit (address 2, bits 5:0), and 0 otherwise.
- R12: After reset, irq is 0, status and enable read 0, and the divisor reads DIV_RST. Read data appears in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Asynchronous serial input, idle high |
| bus_adr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle (a read of address 0 pops) |
| bus_wdat | input | 16 | Write data |
| bus_rdat | output | 16 | Read data, valid the cycle after bus_rd |
| irq | output | 1 | Combined interrupt request |

## Verification
The fill threshold is tried with a burst that stops one byte short of it and then with the byte that reaches it. This separates the threshold path from per-character signalling. A single isolated byte is left unread to show that only the timeout path reports it, and that the report persists until the FIFO is drained. Frames with a low stop bit, with a low stop bit over all-zero data, and a start glitch shorter than half a bit separate framing, break and rejected starts. A burst one byte past FIFO capacity, followed by a change of divisor, shows that the dropped byte is reported and that the FIFO order and bit timing hold.

// File: rtl/uart_rxm_pkg.sv
// Shared register addresses, status bit positions and receiver states.
package uart_rxm_pkg;
    localparam int REG_W = 16;
    localparam int SRC_N = 6;

    // Status word bit positions; bits 5:0 are interrupt sources.
    localparam int S_RDY  = 0;
    localparam int S_OVR  = 1;
    localparam int S_FRM  = 2;
    localparam int S_PAR  = 3;
    localparam int S_BRK  = 4;
    localparam int S_ANY  = 5;
    localparam int S_TMO  = 6;
    localparam int S_THR  = 7;
    localparam int S_NEMP = 8;

    typedef enum logic [1:0] {
        ADR_DATA = 2'd0,
        ADR_STAT = 2'd1,
        ADR_MASK = 2'd2,
        ADR_DIV  = 2'd3
    } reg_adr_e;

    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_START = 3'd1,
        RX_DATA  = 3'd2,
        RX_STOP  = 3'd3,
        RX_HOLD  = 3'd4
    } rx_state_e;
endpackage

// File: rtl/uart_rxm_baud.sv
// Oversample tick generator: one-cycle tick every 'div' clocks (0 acts as 1).
// Assumes 'restart' pulses when the divisor is rewritten so the new period starts cleanly.
module uart_rxm_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             restart,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    // Terminal count of the period counter.
    always_comb lim = (div == '0) ? '0 : div - DIV_W'(1);

    // Period counter with registered tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= lim) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + DIV_W'(1);
            tick <= 1'b0;
        end
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div > DIV_W'(1)) |=> !tick);
endmodule

// File: rtl/uart_rxm_deser.sv
// 8N1 deserializer with 16x oversampling. The start bit is confirmed at mid-bit,
// and data and stop bits are sampled at bit centre. Assumes 'rx' is already synchronised.
// Emits one-cycle pulses: byte_ok (good stop), frm_err (low stop), brk (all-low frame).
module uart_rxm_deser
    import uart_rxm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx,
    output logic       byte_ok,
    output logic [7:0] byte_dat,
    output logic       frm_err,
    output logic       brk
);
    rx_state_e  st;
    logic [3:0] os;
    logic [2:0] bit_idx;
    logic [7:0] shf;

    assign byte_dat = shf;

    // Frame state machine, advancing on oversample ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= RX_IDLE;
            os      <= '0;
            bit_idx <= '0;
            shf     <= '0;
            byte_ok <= 1'b0;
            frm_err <= 1'b0;
            brk     <= 1'b0;
        end else begin
            byte_ok <= 1'b0;
            frm_err <= 1'b0;
            brk     <= 1'b0;
            if (tick) begin
                case (st)
                    RX_IDLE: begin
                        if (!rx) begin
                            st <= RX_START;
                            os <= '0;
                        end
                    end
                    RX_START: begin
                        if (os == 4'd7) begin
                            os      <= '0;
                            bit_idx <= '0;
                            st      <= rx ? RX_IDLE : RX_DATA;
                        end else begin
                            os <= os + 4'd1;
                        end
                    end
                    RX_DATA: begin
                        if (os == 4'd15) begin
                            os  <= '0;
                            shf <= {rx, shf[7:1]};
                            if (bit_idx == 3'd7) st <= RX_STOP;
                            else                 bit_idx <= bit_idx + 3'd1;
                        end else begin
                            os <= os + 4'd1;
                        end
                    end
                    RX_STOP: begin
                        if (os == 4'd15) begin
                            os <= '0;
                            if (rx) begin
                                byte_ok <= 1'b1;
                                st      <= RX_IDLE;
                            end else begin
                                frm_err <= 1'b1;
                                brk     <= (shf == 8'h00);
                                st      <= RX_HOLD;
                            end
                        end else begin
                            os <= os + 4'd1;
                        end
                    end
                    RX_HOLD: begin
                        if (rx) st <= RX_IDLE;
                    end
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end

    // R1
    good_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ok |-> ($past(rx) && $past(tick)));
    // R8
    low_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_err |-> (!$past(rx) && !byte_ok));
endmodule

// File: rtl/uart_rxm_fifo.sv
// Byte FIFO with occupancy count. A push while full is refused (the caller flags overrun).
// Assumes DEPTH is a power of two of at least 2.
module uart_rxm_fifo #(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [7:0]    din,
    input  logic          pop,
    output logic [7:0]    dout,
    output logic [CW-1:0] used,
    output logic          full,
    output logic          empty
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic          do_push;
    logic          do_pop;

    assign full    = (used == CW'(DEPTH));
    assign empty   = (used == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp   <= '0;
            rp   <= '0;
            used <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            case ({do_push, do_pop})
                2'b10:   used <= used + CW'(1);
                2'b01:   used <= used - CW'(1);
                default: used <= used;
            endcase
        end
    end

    // R7
    full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> (used <= $past(used)));
    // R3
    pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !push) |=> (used == $past(used) - CW'(1)));
endmodule

// File: rtl/uart_rxm_timeout.sv
// Free-running idle timer advancing on 'en'. At terminal count (top bit set) it
// clears itself if the FIFO is empty. Otherwise it holds and raises 'flag' until emptiness is seen.
module uart_rxm_timeout #(
    parameter int TO_BITS = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic empty,
    output logic flag
);
    logic [TO_BITS-1:0] cnt;
    logic               at_term;

    assign at_term = cnt[TO_BITS-1];

    // Counter and flag, updated only on enabled cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else if (en) begin
            if (at_term) begin
                if (empty) begin
                    cnt  <= '0;
                    flag <= 1'b0;
                end else begin
                    flag <= 1'b1;
                end
            end else begin
                cnt  <= cnt + TO_BITS'(1);
                flag <= 1'b0;
            end
        end
    end

    // R5
    run_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !at_term) |=> !flag);
    // R5
    hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && at_term && !empty) |=> (flag && at_term));
    // R6
    empty_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && at_term && empty) |=> (!flag && cnt == '0));
    // R6
    idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(flag));
endmodule

// File: rtl/uart_rx_irqmod.sv
// UART receive path with moderated interrupt: synchroniser, tick generator,
// deserializer, FIFO, timeout timer, sticky status, enables and register port.
// Assumes DIV_W <= 16, DEPTH a power of two, 1 <= THRESH <= DEPTH.
module uart_rx_irqmod
    import uart_rxm_pkg::*;
#(
    parameter  int DIV_W   = 16,
    parameter  int DIV_RST = 68,
    parameter  int DEPTH   = 64,
    parameter  int THRESH  = DEPTH / 2,
    parameter  int TO_BITS = 15,
    localparam int CW      = $clog2(DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rxd,
    input  logic [1:0]  bus_adr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [15:0] bus_wdat,
    output logic [15:0] bus_rdat,
    output logic        irq
);
    logic             rx_m, rx_s;
    logic [DIV_W-1:0] div_q;
    logic [SRC_N-1:0] mask_q;
    logic             tick;
    logic             byte_ok, frm_ev, brk_ev;
    logic [7:0]       byte_dat;
    logic [7:0]       fifo_dout;
    logic [CW-1:0]    fifo_used;
    logic             fifo_full, fifo_empty;
    logic             tmo_flag;
    logic             sts_ovr, sts_frm, sts_brk;
    logic             thr, rdy, par;
    logic [SRC_N-1:0] src;
    logic [REG_W-1:0] stat_w;
    logic             wr_div, wr_stat, wr_mask, rd_data;

    assign wr_div  = bus_wr && (reg_adr_e'(bus_adr) == ADR_DIV);
    assign wr_stat = bus_wr && (reg_adr_e'(bus_adr) == ADR_STAT);
    assign wr_mask = bus_wr && (reg_adr_e'(bus_adr) == ADR_MASK);
    assign rd_data = bus_rd && (reg_adr_e'(bus_adr) == ADR_DATA);

    // Two-flop synchroniser for the serial line, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_m <= 1'b1;
            rx_s <= 1'b1;
        end else begin
            rx_m <= rxd;
            rx_s <= rx_m;
        end
    end

    // Divisor and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= DIV_W'(DIV_RST);
            mask_q <= '0;
        end else begin
            if (wr_div)  div_q  <= bus_wdat[DIV_W-1:0];
            if (wr_mask) mask_q <= bus_wdat[SRC_N-1:0];
        end
    end

    uart_rxm_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(div_q), .restart(wr_div), .tick(tick)
    );

    uart_rxm_deser u_deser (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx_s),
        .byte_ok(byte_ok), .byte_dat(byte_dat), .frm_err(frm_ev), .brk(brk_ev)
    );

    uart_rxm_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(byte_ok), .din(byte_dat), .pop(rd_data),
        .dout(fifo_dout), .used(fifo_used), .full(fifo_full), .empty(fifo_empty)
    );

    uart_rxm_timeout #(.TO_BITS(TO_BITS)) u_tmo (
        .clk(clk), .rst_n(rst_n), .en(tick), .empty(fifo_empty), .flag(tmo_flag)
    );

    // Sticky error bits: a new event wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_ovr <= 1'b0;
            sts_frm <= 1'b0;
            sts_brk <= 1'b0;
        end else begin
            sts_ovr <= (byte_ok && fifo_full) || (sts_ovr && !(wr_stat && bus_wdat[S_OVR]));
            sts_frm <= frm_ev || (sts_frm && !(wr_stat && bus_wdat[S_FRM]));
            sts_brk <= brk_ev || (sts_brk && !(wr_stat && bus_wdat[S_BRK]));
        end
    end

    // Source vector and status word.
    always_comb begin
        thr        = (fifo_used >= CW'(THRESH));
        rdy        = thr || tmo_flag;
        par        = 1'b0;
        src        = '0;
        src[S_RDY] = rdy;
        src[S_OVR] = sts_ovr;
        src[S_FRM] = sts_frm;
        src[S_PAR] = par;
        src[S_BRK] = sts_brk;
        src[S_ANY] = sts_ovr || sts_frm || par || sts_brk;
        stat_w          = '0;
        stat_w[SRC_N-1:0] = src;
        stat_w[S_TMO]   = tmo_flag;
        stat_w[S_THR]   = thr;
        stat_w[S_NEMP]  = !fifo_empty;
    end

    // Registered interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(src & mask_q);
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdat <= '0;
        end else if (bus_rd) begin
            case (reg_adr_e'(bus_adr))
                ADR_DATA: bus_rdat <= {7'd0, !fifo_empty, fifo_empty ? 8'h00 : fifo_dout};
                ADR_STAT: bus_rdat <= stat_w;
                ADR_MASK: bus_rdat <= REG_W'(mask_q);
                ADR_DIV:  bus_rdat <= REG_W'(div_q);
                default:  bus_rdat <= '0;
            endcase
        end
    end

    // R7
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ok && fifo_full) |=> sts_ovr);
    // R9
    brk_with_frm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_brk) |-> sts_frm);
endmodule

// File: tb/uart_rx_irqmod_bench.sv
module uart_rx_irqmod_bench;
    localparam int DEPTH   = 16;
    localparam int TO_BITS = 12;
    localparam int DIV_RST = 68;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rxd = 1'b1;
    logic [1:0]  bus_adr = 2'd0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdat = 16'd0;
    logic [15:0] bus_rdat;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    int div_cur = DIV_RST;
    bit done = 1'b0;
    logic [7:0] exp_q[$];

    uart_rx_irqmod #(.DIV_RST(DIV_RST), .DEPTH(DEPTH), .TO_BITS(TO_BITS)) u_uart_rx_irqmod (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .bus_adr(bus_adr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdat(bus_wdat), .bus_rdat(bus_rdat), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] adr, input logic [15:0] dat);
        @(negedge clk);
        bus_adr = adr; bus_wdat = dat; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] adr, output logic [15:0] dat);
        @(negedge clk);
        bus_adr = adr; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        dat = bus_rdat;
    endtask

    // Driver: serialises one frame; bytes expected in the FIFO go to the scoreboard.
    task automatic send_frame(input logic [7:0] b, input logic stop, input bit expect_store);
        int bt;
        bt = 16 * div_cur;
        if (expect_store) exp_q.push_back(b);
        @(negedge clk);
        rxd = 1'b0;
        repeat (bt) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (bt) @(negedge clk);
        end
        rxd = stop;
        repeat (bt) @(negedge clk);
        rxd = 1'b1;
        repeat (bt) @(negedge clk);
    endtask

    // Monitor: pops bytes from the design and compares with the scoreboard.
    task automatic drain(input string req);
        logic [15:0] d;
        for (int k = 0; k < DEPTH + 2; k++) begin
            bus_read(2'd0, d);
            if (d[8] == 1'b0) break;
            if (exp_q.size() == 0) begin
                check(req, d, 16'hFFFF);
            end else begin
                check(req, {8'd0, d[7:0]}, {8'd0, exp_q.pop_front()});
            end
        end
        check(req, 16'(exp_q.size()), 16'd0);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        bit seen;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        check("R12 irq", {15'd0, irq}, 16'd0);
        bus_read(2'd1, r); check("R12 status", r, 16'd0);
        bus_read(2'd2, r); check("R12 enable", r, 16'd0);
        bus_read(2'd3, r); check("R12 R2 divisor reset", r, 16'(DIV_RST));

        // R2 divisor write
        bus_write(2'd3, 16'd4); div_cur = 4;
        bus_read(2'd3, r); check("R2 divisor readback", r, 16'd4);
        bus_write(2'd2, 16'h0001);

        // R4 threshold: one byte short, then reaching it
        send_frame(8'h3C, 1'b1, 1); send_frame(8'hA5, 1'b1, 1);
        send_frame(8'h01, 1'b1, 1); send_frame(8'h80, 1'b1, 1);
        send_frame(8'hFF, 1'b1, 1); send_frame(8'h00, 1'b1, 1);
        send_frame(8'h5A, 1'b1, 1);
        bus_read(2'd1, r); check("R4 below threshold", {14'd0, r[7], r[0]}, 16'd0);
        check("R11 no irq below threshold", {15'd0, irq}, 16'd0);
        send_frame(8'hC3, 1'b1, 1);
        bus_read(2'd1, r); check("R4 at threshold", {14'd0, r[7], r[6]}, 16'b10);
        check("R11 irq at threshold", {15'd0, irq}, 16'd1);
        drain("R3 R1 threshold burst");
        bus_read(2'd1, r); check("R4 after drain", {15'd0, r[7]}, 16'd0);
        repeat (2) @(negedge clk);
        check("R11 irq after drain", {15'd0, irq}, 16'd0);

        // R5 timeout on an isolated byte
        send_frame(8'h96, 1'b1, 1);
        bus_read(2'd1, r); check("R5 no early timeout", {14'd0, r[6], r[7]}, 16'd0);
        check("R5 irq quiet", {15'd0, irq}, 16'd0);
        seen = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (irq) begin seen = 1'b1; break; end
        end
        check("R5 timeout irq", {15'd0, seen}, 16'd1);
        bus_read(2'd1, r); check("R5 R11 timeout status", {14'd0, r[6], r[0]}, 16'b11);
        repeat (3000) @(negedge clk);
        check("R6 timeout persists", {15'd0, irq}, 16'd1);
        drain("R3 timeout byte");
        repeat (20) @(negedge clk);
        bus_read(2'd1, r); check("R6 timeout cleared", {15'd0, r[6]}, 16'd0);
        check("R6 irq cleared", {15'd0, irq}, 16'd0);

        // R1 short start glitch
        @(negedge clk); rxd = 1'b0;
        repeat (12) @(negedge clk); rxd = 1'b1;
        repeat (200) @(negedge clk);
        bus_read(2'd1, r); check("R1 glitch ignored", {14'd0, r[8], r[2]}, 16'd0);

        // R8 framing error, masked then enabled
        bus_write(2'd2, 16'h0000);
        send_frame(8'h55, 1'b0, 0);
        bus_read(2'd1, r);
        check("R8 framing status", {12'd0, r[8], r[5], r[4], r[2]}, 16'b0101);
        check("R11 masked framing", {15'd0, irq}, 16'd0);
        bus_write(2'd2, 16'h0004);
        repeat (2) @(negedge clk);
        check("R11 enabled framing", {15'd0, irq}, 16'd1);
        bus_write(2'd1, 16'h0004);
        bus_read(2'd1, r); check("R10 framing cleared", {14'd0, r[5], r[2]}, 16'd0);
        repeat (2) @(negedge clk);
        check("R10 irq after clear", {15'd0, irq}, 16'd0);

        // R9 break
        bus_write(2'd2, 16'h0010);
        send_frame(8'h00, 1'b0, 0);
        bus_read(2'd1, r);
        check("R9 break status", {12'd0, r[8], r[5], r[4], r[2]}, 16'b0111);
        check("R9 break irq", {15'd0, irq}, 16'd1);
        bus_write(2'd1, 16'h0014);
        bus_read(2'd1, r); check("R10 break cleared", {13'd0, r[5], r[4], r[2]}, 16'd0);

        // R7 overrun
        bus_write(2'd2, 16'h0002);
        for (int i = 0; i < DEPTH; i++) send_frame(8'(i * 7 + 3), 1'b1, 1);
        bus_read(2'd1, r); check("R7 no overrun when full", {15'd0, r[1]}, 16'd0);
        send_frame(8'hEE, 1'b1, 0);
        bus_read(2'd1, r);
        check("R7 overrun status", {13'd0, r[5], r[3], r[1]}, 16'b101);
        check("R7 overrun irq", {15'd0, irq}, 16'd1);
        drain("R7 R3 overrun drop");
        bus_write(2'd1, 16'h0002);
        bus_read(2'd1, r); check("R10 overrun cleared", {13'd0, r[5], r[3], r[1]}, 16'd0);

        // R2 new divisor
        bus_write(2'd3, 16'd6); div_cur = 6;
        send_frame(8'h7E, 1'b1, 1);
        send_frame(8'h81, 1'b1, 1);
        drain("R2 R1 divisor 6");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule